// File: doc/BRIEF.md
# Register-Mapped General-Purpose Pin Controller

This block controls a parameterised number of general-purpose pins from a small memory-mapped register bus. Every pin has a 2-bit mode that decides how the pin's output value and output-enable are formed from the pin's output-register bit: left undriven, actively driven, driven only low (an open-drain emulation that toggles the enable), or released to an external pin multiplexer through a per-pin alternate flag. The pin inputs pass through a configurable synchroniser chain and can be read back as a register.

Software changes outputs in two ways. It can write the whole output register, or it can use the set/clear register, which carries a 2-bit command per pin. The second way changes only the selected pins, so no read-modify-write sequence is needed. The bus is a single-port strobe interface. Read data is registered and appears in the cycle after the read strobe.

Top module: `pin_port_ctrl`

## Requirements
- R1: After reset every mode field is input-only, every output-register bit is 0, and `pinOe`, `pinOut` and `altMode` are all 0.
- R2: The mode register sits at offset 0x0 with pin i in bits [2i+1:2i]. A field value of 00 (input-only) gives output-enable 0, an output value equal to the pin's output-register bit, and alternate flag 0.
- R3: A mode field value of 01 (push-pull) gives output-enable 1 and an output value equal to the pin's output-register bit. The alternate flag is 0.
- R4: A mode field value of 10 (open-drain) holds the pin output value at 0 and makes the output-enable the inverse of the pin's output-register bit. The alternate flag is 0.
- R5: A mode field value of 11 (alternate) gives output-enable 0, an output value equal to the output-register bit, and sets that pin's bit of `altMode`.
- R6: The input register at offset 0x4 holds pin i in bit i. Each bit is taken from `pinIn` through SYNC_STAGES rising-edge flip-flops (0 means a direct path). Writes to offset 0x4 have no effect.
- R7: The output register at offset 0x8 can be written and read, with pin i in bit i.
- R8: The set/clear register at offset 0xC has a 2-bit field per pin in bits [2i+1:2i]. A field of 01 sets the pin's output bit, 10 clears it, and 00 or 11 leaves it unchanged. Reads of this offset return 0.
- R9: `busRdata` shows the addressed register in the cycle after `busRd` is high, and is 0 in any cycle that does not follow a read strobe.
- R10: Unused register bits read as 0. Addresses that are not word-aligned, or that lie at or above 0x10, read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Byte address of the register access |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| pinIn | input | PIN_COUNT | Input value from each pin |
| pinOut | output | PIN_COUNT | Output value for each pin |
| pinOe | output | PIN_COUNT | Output-enable for each pin |
| altMode | output | PIN_COUNT | Per-pin flag that hands the pin to an external multiplexer |

## Verification
All of the state lives in two register fields per pin, and the pin outputs are combinational functions of them. A corrupted mode field or output bit therefore shows up on `pinOut`, `pinOe` or `altMode` in the same cycle as the bad update. It also appears in the read data one cycle after a read strobe. A fault in the synchroniser shows up as input readback arriving a cycle early or late relative to SYNC_STAGES. A decode fault shows up as a register that changes after a write to a neighbouring, reserved or misaligned address, which the next readback of that register exposes.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int DATA_W = 32;
  localparam int MAX_PINS = DATA_W / 2;

  typedef enum logic [1:0] {
    MODE_IN  = 2'b00,
    MODE_PP  = 2'b01,
    MODE_OD  = 2'b10,
    MODE_ALT = 2'b11
  } pinMode_e;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_IN   = 2'd1,
    SEL_OUT  = 2'd2,
    SEL_SC   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrMode;
    logic    wrOut;
    logic    wrSetClr;
    logic    rdHit;
    regSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output regStrobe_t        strobe
);

  localparam int IDX_LSB = 2;

  logic    aligned;
  logic    inRange;
  logic    mapped;
  regSel_e sel;

  always_comb begin
    aligned = (busAddr[IDX_LSB-1:0] == '0);
    inRange = ((busAddr >> (IDX_LSB + 2)) == '0);
    mapped  = aligned && inRange;
    sel     = regSel_e'(busAddr[IDX_LSB+1:IDX_LSB]);
  end

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = sel;
    strobe.rdHit    = busRd && mapped;
    strobe.wrMode   = busWr && mapped && (sel == SEL_MODE);
    strobe.wrOut    = busWr && mapped && (sel == SEL_OUT);
    strobe.wrSetClr = busWr && mapped && (sel == SEL_SC);
  end

endmodule

// File: rtl/gpio_pin_map.sv
module gpio_pin_map
  import gpio_pkg::*;
(
  input  pinMode_e mode,
  input  logic     outBit,
  output logic     padOut,
  output logic     padOe,
  output logic     padAlt
);

  always_comb begin
    padOut = outBit;
    padOe  = 1'b0;
    padAlt = 1'b0;
    unique case (mode)
      MODE_IN:  ;
      MODE_PP:  padOe = 1'b1;
      MODE_OD: begin
        padOut = 1'b0;
        padOe  = ~outBit;
      end
      MODE_ALT: padAlt = 1'b1;
      default:  ;
    endcase
  end

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int PIN_COUNT   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  regStrobe_t             strobe,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [PIN_COUNT-1:0]   pinIn,
  output logic [DATA_W-1:0]      rdata,
  output logic [2*PIN_COUNT-1:0] modeBits,
  output logic [PIN_COUNT-1:0]   outBits,
  output logic [PIN_COUNT-1:0]   pinOut,
  output logic [PIN_COUNT-1:0]   pinOe,
  output logic [PIN_COUNT-1:0]   altMode
);

  localparam int MODE_W = 2 * PIN_COUNT;

  logic [PIN_COUNT-1:0] syncBits;
  logic [PIN_COUNT-1:0] outNext;
  logic [DATA_W-1:0]    readWord;

  // input synchroniser
  generate
    if (SYNC_STAGES == 0) begin : g_noSync
      assign syncBits = pinIn;
    end else begin : g_sync
      logic [PIN_COUNT-1:0] chain [SYNC_STAGES];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int s = 0; s < SYNC_STAGES; s++) chain[s] <= '0;
        end else begin
          chain[0] <= pinIn;
          for (int s = 1; s < SYNC_STAGES; s++) chain[s] <= chain[s-1];
        end
      end
      assign syncBits = chain[SYNC_STAGES-1];
    end
  endgenerate

  // mode register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              modeBits <= '0;
    else if (strobe.wrMode) modeBits <= wdata[MODE_W-1:0];
  end

  // output register: a set/clear command outranks a plain write per pin
  generate
    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_outNext
      logic [1:0] cmd;
      assign cmd = wdata[2*i +: 2];
      always_comb begin
        outNext[i] = outBits[i];
        if (strobe.wrOut) outNext[i] = wdata[i];
        if (strobe.wrSetClr) begin
          if (cmd == 2'b01)      outNext[i] = 1'b1;
          else if (cmd == 2'b10) outNext[i] = 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outBits <= '0;
    else       outBits <= outNext;
  end

  // per-pin drive mapping
  generate
    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
      gpio_pin_map u_map (
        .mode   (pinMode_e'(modeBits[2*i +: 2])),
        .outBit (outBits[i]),
        .padOut (pinOut[i]),
        .padOe  (pinOe[i]),
        .padAlt (altMode[i])
      );
    end
  endgenerate

  // read path
  always_comb begin
    readWord = '0;
    unique case (strobe.rdSel)
      SEL_MODE: readWord[MODE_W-1:0]    = modeBits;
      SEL_IN:   readWord[PIN_COUNT-1:0] = syncBits;
      SEL_OUT:  readWord[PIN_COUNT-1:0] = outBits;
      SEL_SC:   readWord                = '0;
      default:  readWord                = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdata <= '0;
    else if (strobe.rdHit) rdata <= readWord;
    else                   rdata <= '0;
  end

endmodule

// File: rtl/pin_port_ctrl.sv
module pin_port_ctrl
  import gpio_pkg::*;
#(
  parameter int PIN_COUNT   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busRd,
  input  logic                 busWr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic [PIN_COUNT-1:0] altMode
);

  initial begin
    if (PIN_COUNT < 1 || PIN_COUNT > MAX_PINS)
      $error("PIN_COUNT out of range");
    if (ADDR_W < 4)
      $error("ADDR_W too small for the register map");
  end

  regStrobe_t             strobe;
  logic [2*PIN_COUNT-1:0] modeBits;
  logic [PIN_COUNT-1:0]   outBits;

  gpio_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .strobe  (strobe)
  );

  gpio_datapath #(
    .PIN_COUNT   (PIN_COUNT),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wdata    (busWdata),
    .pinIn    (pinIn),
    .rdata    (busRdata),
    .modeBits (modeBits),
    .outBits  (outBits),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .altMode  (altMode)
  );

endmodule

// File: rtl/pin_port_ctrl_sva.sv
module pin_port_ctrl_sva #(
  parameter int PIN_COUNT = 8,
  parameter int ADDR_W    = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [ADDR_W-1:0]      busAddr,
  input logic                   busRd,
  input logic                   busWr,
  input logic [31:0]            busWdata,
  input logic [31:0]            busRdata,
  input logic [PIN_COUNT-1:0]   pinOut,
  input logic [PIN_COUNT-1:0]   pinOe,
  input logic [PIN_COUNT-1:0]   altMode,
  input logic [2*PIN_COUNT-1:0] modeBits,
  input logic [PIN_COUNT-1:0]   outBits
);

  logic scAccess;
  logic unmapped;
  assign scAccess = (busAddr == ADDR_W'(12));
  assign unmapped = (busAddr[1:0] != 2'b00) || ((busAddr >> 4) != '0);

  p_reset_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (outBits == '0 && modeBits == '0 && pinOe == '0 && altMode == '0));

  p_rd_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> busRdata == '0);

  p_sc_read_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && scAccess) |=> busRdata == '0);

  p_no_write_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busWr || unmapped) |=> ($stable(outBits) && $stable(modeBits)));

  generate
    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pinChk
      p_alt_undriven_r5: assert property (@(posedge clk) disable iff (!rstN)
        altMode[i] |-> !pinOe[i]);

      p_od_low_r4: assert property (@(posedge clk) disable iff (!rstN)
        (modeBits[2*i +: 2] == 2'b10) |-> (!pinOut[i] && (pinOe[i] != outBits[i])));

      p_pp_drive_r3: assert property (@(posedge clk) disable iff (!rstN)
        (modeBits[2*i +: 2] == 2'b01) |-> (pinOe[i] && pinOut[i] == outBits[i]));

      p_set_r8: assert property (@(posedge clk) disable iff (!rstN)
        (busWr && scAccess && busWdata[2*i +: 2] == 2'b01) |=> outBits[i]);

      p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
        (busWr && scAccess && busWdata[2*i +: 2] == 2'b10) |=> !outBits[i]);
    end
  endgenerate

endmodule

bind pin_port_ctrl pin_port_ctrl_sva #(
  .PIN_COUNT (PIN_COUNT),
  .ADDR_W    (ADDR_W)
) u_sva (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busRd    (busRd),
  .busWr    (busWr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .pinOut   (pinOut),
  .pinOe    (pinOe),
  .altMode  (altMode),
  .modeBits (modeBits),
  .outBits  (outBits)
);

// File: tb/pin_port_ctrl_test.sv
module pin_port_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int PINS       = 8;
  localparam int STAGES     = 2;
  localparam int AW         = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [AW-1:0]   busAddr = '0;
  logic            busRd = 1'b0;
  logic            busWr = 1'b0;
  logic [31:0]     busWdata = '0;
  logic [31:0]     busRdata;
  logic [PINS-1:0] pinIn = '0;
  logic [PINS-1:0] pinOut;
  logic [PINS-1:0] pinOe;
  logic [PINS-1:0] altMode;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_port_ctrl #(.PIN_COUNT(PINS), .SYNC_STAGES(STAGES), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .altMode(altMode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  // expected pin behaviour derived from the mode table
  task automatic checkPins(input string req, input logic [15:0] modes, input logic [PINS-1:0] o);
    logic [PINS-1:0] eOut, eOe, eAlt;
    for (int i = 0; i < PINS; i++) begin
      case (modes[2*i +: 2])
        2'b00: begin eOut[i] = o[i]; eOe[i] = 1'b0;  eAlt[i] = 1'b0; end
        2'b01: begin eOut[i] = o[i]; eOe[i] = 1'b1;  eAlt[i] = 1'b0; end
        2'b10: begin eOut[i] = 1'b0; eOe[i] = ~o[i]; eAlt[i] = 1'b0; end
        default: begin eOut[i] = o[i]; eOe[i] = 1'b0; eAlt[i] = 1'b1; end
      endcase
    end
    check({req, " pinOut"}, 32'(pinOut), 32'(eOut));
    check({req, " pinOe"}, 32'(pinOe), 32'(eOe));
    check({req, " altMode"}, 32'(altMode), 32'(eAlt));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 pinOe", 32'(pinOe), 0);
    check("R1 pinOut", 32'(pinOut), 0);
    check("R1 altMode", 32'(altMode), 0);
    busRead(8'h00, d); check("R1 mode reg", d, 0);
    busRead(8'h08, d); check("R1 out reg", d, 0);
  endtask

  task automatic t_outReg;
    logic [31:0] d;
    busWrite(8'h08, 32'h0000_00A5);
    busRead(8'h08, d); check("R7 out readback", d, 32'hA5);
    checkPins("R2 input-only", 16'h0000, 8'hA5);
    busWrite(8'h08, 32'hFFFF_FFFF);
    busRead(8'h08, d); check("R10 unused out bits", d, 32'hFF);
  endtask

  task automatic t_modes;
    logic [31:0] d;
    logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'h55, 8'hAA};
    busWrite(8'h00, 32'hFFFF_FA50);
    busRead(8'h00, d); check("R10 mode readback width", d, 32'hFA50);
    foreach (pats[k]) begin
      busWrite(8'h08, 32'(pats[k]));
      checkPins("R3 R4 R5 mixed modes", 16'hFA50, pats[k]);
    end
    busWrite(8'h00, 32'h0000_5555);
    checkPins("R3 all push-pull", 16'h5555, 8'hAA);
    busWrite(8'h00, 32'h0000_AAAA);
    checkPins("R4 all open-drain", 16'hAAAA, 8'hAA);
    busWrite(8'h00, 32'h0000_FFFF);
    checkPins("R5 all alternate", 16'hFFFF, 8'hAA);
    busWrite(8'h00, 32'h0);
  endtask

  task automatic t_setClr;
    logic [31:0] d;
    busWrite(8'h08, 32'h0F);
    busWrite(8'h0C, 32'h0000_400E);
    busRead(8'h08, d); check("R8 set/clear result", d, 32'h8E);
    busWrite(8'h0C, 32'h0000_FFFF);
    busRead(8'h08, d); check("R8 all 11 no change", d, 32'h8E);
    busWrite(8'h0C, 32'h0000_0000);
    busRead(8'h08, d); check("R8 all 00 no change", d, 32'h8E);
    busWrite(8'h0C, 32'h0000_5555);
    busRead(8'h08, d); check("R8 set all", d, 32'hFF);
    busWrite(8'h0C, 32'h0000_AAAA);
    busRead(8'h08, d); check("R8 clear all", d, 32'h00);
    busRead(8'h0C, d); check("R8 set/clear reads 0", d, 0);
  endtask

  task automatic t_input;
    logic [31:0] d;
    @(negedge clk); pinIn = 8'h3C;
    busRead(8'h04, d); check("R6 sync not yet through", d, 32'h00);
    busRead(8'h04, d); check("R6 sync delivered", d, 32'h3C);
    busWrite(8'h04, 32'hFF);
    busRead(8'h04, d); check("R6 write ignored", d, 32'h3C);
    busRead(8'h08, d); check("R6 write leaves out", d, 32'h00);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    busWrite(8'h08, 32'h33);
    busWrite(8'h10, 32'hFFFF_FFFF);
    busWrite(8'h09, 32'hFFFF_FFFF);
    busWrite(8'h01, 32'hFFFF_FFFF);
    busWrite(8'h4C, 32'h0000_5555);
    busRead(8'h08, d); check("R10 out untouched", d, 32'h33);
    busRead(8'h00, d); check("R10 mode untouched", d, 32'h00);
    busRead(8'h10, d); check("R10 high addr reads 0", d, 0);
    busRead(8'h06, d); check("R10 misaligned reads 0", d, 0);
  endtask

  task automatic t_readTiming;
    logic [31:0] d;
    busRead(8'h08, d); check("R9 read data", d, 32'h33);
    @(negedge clk); check("R9 idle data zero", busRdata, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_outReg();
    t_modes();
    t_setClr();
    t_input();
    t_unmapped();
    t_readTiming();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule